// File: doc/BRIEF.md
# Armed Sync Capture Buffer

The block takes in a stream of samples and writes them into a small on-chip memory. The memory is then read back over a simple memory-mapped port. A second small port holds the control and status words. The point at which capture starts has three settings.

- **Refill-on-read:** the buffer takes the first samples it sees. It takes new ones only after the last word of the memory has been read out.
- **Restart-on-sync:** every sample marked as a sync restarts the capture at the first word.
- **One-shot:** software arms the buffer. The next sync then starts a count of valid samples, and the capture begins when that count runs out. After one fill the buffer stays frozen until it is armed again.

The input side uses valid/ready. The sink never applies back-pressure: `in_ready` is always high, so every cycle with `in_valid` high transfers one sample. `in_sync` has meaning only in a cycle with `in_valid` high, where it marks that sample as a sync sample.

Both read ports return data in the cycle after the read strobe. One register offset has two uses: a read returns the count of valid samples since the last sync, and a write arms the buffer.

Top module: `sync_capture_buffer`

## Requirements
- R1: After reset the sync count, word count, valid count and delay all read 0, offset 7 reads the VERSION parameter, and offsets 4, 5 and 6 read 0.
- R2: With `mode_sync` low, the first DEPTH valid samples are written to addresses 0 to DEPTH-1 in arrival order. Storing then stops, and the word count holds at DEPTH.
- R3: With `mode_sync` low and the buffer full, a memory read of address DEPTH-1 clears the word count to 0. The next valid sample is then stored at address 0.
- R4: With `mode_sync` high and a delay of 0, every valid sample that has `in_sync` set is stored at address 0, and the word count becomes 1. Later valid samples follow in order, overwriting the old data, until the buffer is full.
- R5: With `mode_sync` high and a delay D other than 0, a write to offset 2 arms the buffer. On the next sync sample, that sample and the D-1 valid samples after it are skipped, and the DEPTH valid samples that follow are stored.
- R6: With `mode_sync` high and a delay other than 0, sync samples do not start a capture while the buffer is full, in any state other than armed. This covers the time after an armed capture has completed.
- R7: Offset 0 reads the number of sync samples seen since the last memory read of address DEPTH-1. That read clears the count, and the clear wins over a sync in the same cycle.
- R8: Offset 1 reads the number of words stored in the current fill.
- R9: Offset 2 reads the number of valid samples received after the most recent sync sample. A sync sample sets this count to 0.
- R10: Offset 3 holds a DLY_W-bit delay, readable and writable, returned zero-extended. Writes to offsets 0, 1 and 4 to 7 change nothing.
- R11: Register and memory read data appear in the cycle after `reg_rd` or `ram_rd`. Memory data bits from DATA_W upward read 0.
- R12: `in_ready` is always high. `in_sync` has no effect in cycles where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sync | input | 1 | 0 selects refill-on-read; 1 selects sync operation (one-shot when the delay is nonzero) |
| in_valid | input | 1 | A sample is present |
| in_ready | output | 1 | Always 1 |
| in_data | input | DATA_W | Sample value |
| in_sync | input | 1 | Marks the sample as a sync sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| ram_rd | input | 1 | Memory read strobe |
| ram_addr | input | AW | Memory word address |
| ram_rdata | output | 32 | Memory read data, one cycle after `ram_rd` |

## Verification
The bench builds the block with DEPTH 16, DATA_W 20 and DLY_W 16.

A 16-word buffer fills in tens of cycles, so a single run covers a full buffer, a refill, a partial overwrite and two armed captures with different delays. A data width of 20 leaves the upper 12 bits of every memory read to be checked as zero.

Sample values, idle gaps and stray `in_sync` levels on idle cycles come from a seeded `$urandom`.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  typedef enum logic [2:0] {
    CB_IDLE,
    CB_ARMED,
    CB_DELAY,
    CB_FILL,
    CB_FULL
  } cb_state_e;

  localparam logic [2:0] OFS_SYNC_CNT  = 3'd0;
  localparam logic [2:0] OFS_WORD_CNT  = 3'd1;
  localparam logic [2:0] OFS_VALID_ARM = 3'd2;
  localparam logic [2:0] OFS_DELAY     = 3'd3;
  localparam logic [2:0] OFS_VERSION   = 3'd7;
endpackage

// File: rtl/capbuf_mem.sv
module capbuf_mem #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 20,
  parameter int BUS_W  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [BUS_W-1:0]  rd_data
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= store[rd_addr];
  end

  generate
    if (BUS_W > DATA_W) begin : g_pad
      assign rd_data = {{(BUS_W-DATA_W){1'b0}}, rd_q};
    end else begin : g_trim
      assign rd_data = rd_q[BUS_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/capbuf_ctrl.sv
module capbuf_ctrl
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DLY_W = 16,
  parameter int CNT_W = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sync,
  input  logic             mode_sync,
  input  logic [DLY_W-1:0] dly,
  input  logic             arm,
  input  logic             last_rd,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [AW:0]      word_cnt,
  output logic [CNT_W-1:0] sync_cnt,
  output logic [CNT_W-1:0] valid_cnt
);
  localparam logic [AW:0] LAST = (AW+1)'(DEPTH-1);

  cb_state_e        st, st_n;
  logic [AW:0]      wc_n;
  logic [DLY_W-1:0] dl, dl_n;
  logic             sync_ev, oneshot;

  assign sync_ev = in_valid & in_sync;
  assign oneshot = mode_sync & (dly != '0);

  always_comb begin
    st_n    = st;
    wc_n    = word_cnt;
    dl_n    = dl;
    wr_en   = 1'b0;
    wr_addr = word_cnt[AW-1:0];
    if (!mode_sync) begin
      case (st)
        CB_FILL: if (in_valid) begin
          wr_en = 1'b1;
          wc_n  = word_cnt + 1'b1;
          if (word_cnt == LAST) st_n = CB_FULL;
        end
        CB_FULL: if (last_rd) begin
          wc_n = '0;
          st_n = CB_FILL;
        end
        default: begin
          wc_n = '0;
          st_n = CB_FILL;
        end
      endcase
    end else if (!oneshot) begin
      if (sync_ev) begin
        wr_en   = 1'b1;
        wr_addr = '0;
        wc_n    = (AW+1)'(1);
        st_n    = CB_FILL;
      end else if (st == CB_FILL && in_valid) begin
        wr_en = 1'b1;
        wc_n  = word_cnt + 1'b1;
        if (word_cnt == LAST) st_n = CB_FULL;
      end
    end else if (arm) begin
      st_n = CB_ARMED;
    end else begin
      case (st)
        CB_ARMED: if (sync_ev) begin
          wc_n = '0;
          dl_n = dly - 1'b1;
          st_n = CB_DELAY;
        end
        CB_DELAY: if (in_valid) begin
          if (dl == '0) begin
            wr_en   = 1'b1;
            wr_addr = '0;
            wc_n    = (AW+1)'(1);
            st_n    = CB_FILL;
          end else begin
            dl_n = dl - 1'b1;
          end
        end
        CB_FILL: if (in_valid) begin
          wr_en = 1'b1;
          wc_n  = word_cnt + 1'b1;
          if (word_cnt == LAST) st_n = CB_FULL;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= CB_IDLE;
      word_cnt <= '0;
      dl       <= '0;
    end else begin
      st       <= st_n;
      word_cnt <= wc_n;
      dl       <= dl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sync_cnt <= '0;
    else if (last_rd) sync_cnt <= '0;
    else if (sync_ev) sync_cnt <= sync_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        valid_cnt <= '0;
    else if (sync_ev)  valid_cnt <= '0;
    else if (in_valid) valid_cnt <= valid_cnt + 1'b1;
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= (AW+1)'(DEPTH));
  p_full_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sync && st == CB_FULL && !last_rd) |=> $stable(word_cnt));
  p_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sync && st == CB_FULL && last_rd) |=> word_cnt == '0);
  p_sync_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sync && dly == '0 && sync_ev) |=> word_cnt == (AW+1)'(1));
  p_one_shot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (oneshot && st == CB_FULL && !arm) |=> $stable(word_cnt));
  p_sync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_rd |=> sync_cnt == '0);
  p_valid_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ev |=> valid_cnt == '0);
endmodule

// File: rtl/capbuf_regs.sv
module capbuf_regs
  import capbuf_pkg::*;
#(
  parameter int          DEPTH   = 16,
  parameter int          DLY_W   = 16,
  parameter int          CNT_W   = 32,
  parameter int          BUS_W   = 32,
  parameter logic [31:0] VERSION = 32'h1,
  localparam int         AW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] sync_cnt,
  input  logic [AW:0]      word_cnt,
  input  logic [CNT_W-1:0] valid_cnt,
  output logic [DLY_W-1:0] dly,
  output logic             arm,
  output logic [BUS_W-1:0] rdata
);
  logic [BUS_W-1:0] rmux;

  assign arm = wr && (addr == OFS_VALID_ARM);

  always_ff @(posedge clk) begin
    if (!rst_n)                          dly <= '0;
    else if (wr && addr == OFS_DELAY)    dly <= wdata[DLY_W-1:0];
  end

  always_comb begin
    case (addr)
      OFS_SYNC_CNT:  rmux = BUS_W'(sync_cnt);
      OFS_WORD_CNT:  rmux = BUS_W'(word_cnt);
      OFS_VALID_ARM: rmux = BUS_W'(valid_cnt);
      OFS_DELAY:     rmux = BUS_W'(dly);
      OFS_VERSION:   rmux = BUS_W'(VERSION);
      default:       rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rmux;
  end

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr >= 3'd4 && addr <= 3'd6) |=> rdata == '0);
  p_delay_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_DELAY) |=> $stable(dly));
endmodule

// File: rtl/sync_capture_buffer.sv
module sync_capture_buffer #(
  parameter int          DEPTH   = 16,
  parameter int          DATA_W  = 20,
  parameter int          DLY_W   = 16,
  parameter logic [31:0] VERSION = 32'h1,
  localparam int         AW      = $clog2(DEPTH),
  localparam int         BUS_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sync,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sync,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              ram_rd,
  input  logic [AW-1:0]     ram_addr,
  output logic [BUS_W-1:0]  ram_rdata
);
  logic             wr_en, arm, last_rd;
  logic [AW-1:0]    wr_addr;
  logic [AW:0]      word_cnt;
  logic [BUS_W-1:0] sync_cnt, valid_cnt;
  logic [DLY_W-1:0] dly;

  assign in_ready = 1'b1;
  assign last_rd  = ram_rd && (ram_addr == AW'(DEPTH-1));

  capbuf_ctrl #(.DEPTH(DEPTH), .DLY_W(DLY_W), .CNT_W(BUS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
    .mode_sync(mode_sync), .dly(dly), .arm(arm), .last_rd(last_rd),
    .wr_en(wr_en), .wr_addr(wr_addr), .word_cnt(word_cnt),
    .sync_cnt(sync_cnt), .valid_cnt(valid_cnt)
  );

  capbuf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W), .BUS_W(BUS_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(in_data), .rd_en(ram_rd), .rd_addr(ram_addr), .rd_data(ram_rdata)
  );

  capbuf_regs #(.DEPTH(DEPTH), .DLY_W(DLY_W), .CNT_W(BUS_W), .BUS_W(BUS_W),
                .VERSION(VERSION)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .sync_cnt(sync_cnt), .word_cnt(word_cnt),
    .valid_cnt(valid_cnt), .dly(dly), .arm(arm), .rdata(reg_rdata)
  );
endmodule

// File: tb/sync_capture_buffer_bench.sv
module sync_capture_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int DATA_W = 20;
  localparam int DLY_W  = 16;
  localparam int AW     = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, mode_sync = 0;
  logic in_valid = 0, in_sync = 0, in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic reg_wr = 0, reg_rd = 0, ram_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, ram_rdata;
  logic [AW-1:0] ram_addr = '0;

  int checks = 0, errors = 0;
  int n_sent = 0, sc = 0, vc = 0;
  bit done = 0;
  logic [DATA_W-1:0] log_d [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_capture_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DLY_W(DLY_W)) u_sync_capture_buffer (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_sync(in_sync),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_rdata(ram_rdata)
  );

  function automatic logic [31:0] exp_word(int idx);
    return 32'(log_d[idx]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // entered and left at a negedge
  task automatic send(bit s);
    in_valid = 1; in_sync = s; in_data = DATA_W'($urandom);
    log_d[n_sent] = in_data; n_sent++;
    if (s) begin sc++; vc = 0; end else vc++;
    @(negedge clk);
    in_valid = 0;
    repeat ($urandom_range(0, 2)) begin
      in_sync = 1'($urandom);   // R12: stray sync with no valid
      @(negedge clk);
    end
    in_sync = 0;
  endtask

  task automatic send_n(int n);
    for (int i = 0; i < n; i++) send(1'b0);
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a; @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic reg_write(logic [2:0] a, logic [31:0] v);
    reg_wr = 1; reg_addr = a; reg_wdata = v; @(negedge clk); reg_wr = 0;
  endtask

  task automatic ram_read(int a, output logic [31:0] d);
    ram_rd = 1; ram_addr = AW'(a); @(negedge clk); ram_rd = 0; d = ram_rdata;
    if (a == DEPTH-1) sc = 0;
  endtask

  task automatic check_buffer(int base, int upto, string req);
    logic [31:0] v;
    for (int i = 0; i < upto; i++) begin
      ram_read(i, v);
      chk(req, v, exp_word(base + i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base, p, s, t;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    reg_read(3'd0, v); chk("R1 sync count", v, 0);
    reg_read(3'd1, v); chk("R1 word count", v, 0);
    reg_read(3'd2, v); chk("R1 valid count", v, 0);
    reg_read(3'd3, v); chk("R1 delay", v, 0);
    reg_read(3'd7, v); chk("R1 version", v, 1);
    for (int a = 4; a < 7; a++) begin reg_read(3'(a), v); chk("R1 reserved", v, 0); end
    chk("R12 in_ready", 32'(in_ready), 1);

    // R2 free-running fill, stops when full
    for (int i = 0; i < 20; i++) send(($urandom % 4) == 0);
    reg_read(3'd0, v); chk("R7 sync count", v, 32'(sc));
    reg_read(3'd1, v); chk("R2 word count full", v, DEPTH);
    reg_read(3'd2, v); chk("R9 valid count", v, 32'(vc));
    // R10: writes to read-only offsets change nothing
    reg_write(3'd0, 32'h55); reg_write(3'd1, 32'h3); reg_write(3'd5, 32'h9); reg_write(3'd7, 32'h0);
    reg_read(3'd0, v); chk("R10 sync count kept", v, 32'(sc));
    reg_read(3'd1, v); chk("R10 word count kept", v, DEPTH);
    reg_read(3'd5, v); chk("R10 reserved kept zero", v, 0);
    reg_read(3'd7, v); chk("R10 version kept", v, 1);
    check_buffer(0, DEPTH, "R2 stored data");

    // R3 refill after last word read, R7 cleared
    reg_read(3'd0, v); chk("R7 cleared by last read", v, 0);
    reg_read(3'd1, v); chk("R3 word count cleared", v, 0);
    base = n_sent;
    send_n(DEPTH + 2);
    check_buffer(base, DEPTH, "R3 refilled data");

    // R4 sync mode, delay 0
    mode_sync = 1;
    send_n(5);
    p = n_sent; send(1'b1); send_n(19);
    reg_read(3'd1, v); chk("R8 word count full", v, DEPTH);
    check_buffer(p, DEPTH, "R4 capture from sync");
    t = n_sent; send(1'b1); send_n(3);
    reg_read(3'd1, v); chk("R8 partial word count", v, 4);
    check_buffer(t, 4, "R4 overwrite");
    ram_read(4, v); chk("R4 old data kept", v, exp_word(p + 4));

    // R6 one-shot mode: full, not armed, sync ignored
    reg_write(3'd3, 32'd3);
    reg_read(3'd3, v); chk("R10 delay readback", v, 3);
    send_n(12);
    send(1'b1); send_n(2);
    reg_read(3'd1, v); chk("R6 word count unchanged", v, DEPTH);
    ram_read(0, v); chk("R6 sync before arm ignored", v, exp_word(t));

    // R5 armed capture with delay 3
    reg_write(3'd2, 32'h1);
    send_n(2);
    s = n_sent; send(1'b1); send_n(3 + DEPTH + 2);
    reg_read(3'd1, v); chk("R5 word count", v, DEPTH);
    check_buffer(s + 3, DEPTH, "R5 delayed capture");
    send(1'b1); send_n(5);
    reg_read(3'd2, v); chk("R9 valid count after sync", v, 5);
    ram_read(0, v); chk("R6 no capture after completion", v, exp_word(s + 3));
    reg_read(3'd1, v); chk("R6 word count held", v, DEPTH);

    // R5 re-arm with delay 1
    reg_write(3'd3, 32'd1);
    reg_write(3'd2, 32'h0);
    t = n_sent; send(1'b1); send_n(DEPTH + 1);
    check_buffer(t + 1, DEPTH, "R5 re-armed capture");
    reg_read(3'd0, v); chk("R7 cleared after read", v, 32'(sc));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule